// File: doc/BRIEF.md
# Age-Ordered Issue Queue with Register Valid Table

This block is a shared holding queue between the decode stage and two kinds of execution unit: arithmetic and memory. Decode offers one instruction per cycle on a valid/ready port. Each instruction carries a unit class, a destination register number and two source register numbers. An instruction is accepted only when three things hold at once: a queue slot is free, the rename allocator reports a free physical register, and the reorder allocator reports a free slot. Entering the queue is called dispatch.

Leaving the queue is called issue, and it happens on a separate output port. Each cycle the block looks for entries whose two sources are marked valid in a table holding one valid bit per architectural register, and whose target unit reports ready. Of those entries, the one dispatched earliest is issued. Issue clears the valid bit of the destination register, so later consumers of that register hold back. A completion writeback sets the bit again.

Back-pressure rules are as follows. A transfer on the dispatch port takes place in a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is a function of registered queue occupancy and the two allocator inputs only; it never depends on `disp_valid` or on the unit ready inputs. The issue port has no acknowledge. Each unit's ready input is sampled in the same cycle, and a unit that reports ready must accept the issue.

Top module: `shelf_issue`

## Requirements
- R1: After reset the queue is empty, every register is marked valid, nothing issues, and `disp_ready` is high whenever both allocator inputs are high.
- R2: `disp_ready` is high exactly when a queue slot is free and both `ren_free` and `rob_free` are high. An offer made while `disp_ready` is low is dropped, and nothing from it ever issues.
- R3: An entry can issue only when both of its source registers read valid in the register table. An entry dispatched in a cycle can issue no earlier than the next cycle.
- R4: `disp_cls` 0 selects the arithmetic unit and 1 selects the memory unit. `iss_unit` is one-hot, with bit 0 for arithmetic and bit 1 for memory. An entry issues only when the ready input of its own unit is high. `iss_unit` is zero when nothing issues.
- R5: On issue, the destination register becomes invalid from the next cycle. Entries reading that register do not issue until a writeback restores it.
- R6: A writeback sets its register valid from the next cycle. No entry issues on the strength of that writeback in the same cycle.
- R7: When a writeback and an issue name the same register in the same cycle, the register ends up invalid.
- R8: Among entries that are eligible in a cycle, the earliest dispatched issues, regardless of which slot each entry occupies. `iss_rd`, `iss_rs1` and `iss_rs2` carry that entry's fields.
- R9: With 8 entries held, `disp_ready` is low. When both allocator inputs are high, a full queue is the only reason for a stall.
- R10: At most one entry issues per cycle. An issued entry leaves the queue at the following clock edge and never issues twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Decode offers an instruction |
| disp_ready | output | 1 | Queue can take the offer this cycle |
| disp_cls | input | 1 | Unit class: 0 arithmetic, 1 memory |
| disp_rd | input | 5 | Destination register |
| disp_rs1 | input | 5 | First source register |
| disp_rs2 | input | 5 | Second source register |
| ren_free | input | 1 | A rename register is available |
| rob_free | input | 1 | A reorder slot is available |
| alu_ready | input | 1 | Arithmetic unit can accept an issue |
| mem_ready | input | 1 | Memory unit can accept an issue |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_unit | output | 2 | One-hot target unit of the issue |
| iss_rd | output | 5 | Destination of the issuing entry |
| iss_rs1 | output | 5 | First source of the issuing entry |
| iss_rs2 | output | 5 | Second source of the issuing entry |
| wb_valid | input | 1 | A completion writes back this cycle |
| wb_rd | input | 5 | Register restored by the writeback |

## Verification
Issue and writeback can both touch the same register-table bit in one clock. The bench provokes this with a directed case: an entry issues with destination 5 while a writeback to register 5 arrives in the same cycle, and a consumer of register 5 is already queued. The collision is judged correct when that consumer stays held until a later, separate writeback, and issues exactly one cycle after it. A long randomised run over a small register subset produces further collisions, and also dispatch into a slot being freed in the same cycle. It compares every cycle against an in-order model of the queue.

// File: rtl/shelf_pkg.sv
package shelf_pkg;

  localparam int NUM_UNITS = 2;

  typedef enum logic {
    CLS_ALU = 1'b0,
    CLS_MEM = 1'b1
  } unit_cls_e;

  function automatic logic [NUM_UNITS-1:0] unit_onehot(input logic cls);
    logic [NUM_UNITS-1:0] v;
    v = '0;
    v[cls] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/shelf_scoreboard.sv
module shelf_scoreboard #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_idx,
  output logic [NREG-1:0] valid_o
);

  logic [NREG-1:0] vld_q;

  // clear is applied after set so a same-cycle clash leaves the bit low
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '1;
    end else begin
      if (set_en) vld_q[set_idx] <= 1'b1;
      if (clr_en) vld_q[clr_idx] <= 1'b0;
    end
  end

  assign valid_o = vld_q;

endmodule

// File: rtl/shelf_alloc.sv
module shelf_alloc #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  output logic             found,
  output logic [IW-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/shelf_age_pick.sv
module shelf_age_pick #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         req,
  input  logic [DEPTH-1:0][IW-1:0] age,
  output logic                     gnt_any,
  output logic [IW-1:0]            gnt_idx
);

  logic [DEPTH-1:0][DEPTH-1:0] blk;
  logic [DEPTH-1:0]            gnt;

  // entry gi loses if any other requesting entry carries a smaller age rank
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
    for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
      if (gi == gj) begin : g_self
        assign blk[gi][gj] = 1'b0;
      end else begin : g_other
        assign blk[gi][gj] = req[gj] && (age[gj] < age[gi]);
      end
    end
    assign gnt[gi] = req[gi] && !(|blk[gi]);
  end

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (gnt[i]) gnt_idx = IW'(i);
    end
  end

  assign gnt_any = |gnt;

endmodule

// File: rtl/shelf_issue.sv
module shelf_issue
  import shelf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  output logic                 disp_ready,
  input  logic                 disp_cls,
  input  logic [RW-1:0]        disp_rd,
  input  logic [RW-1:0]        disp_rs1,
  input  logic [RW-1:0]        disp_rs2,
  input  logic                 ren_free,
  input  logic                 rob_free,
  input  logic                 alu_ready,
  input  logic                 mem_ready,
  output logic                 iss_valid,
  output logic [NUM_UNITS-1:0] iss_unit,
  output logic [RW-1:0]        iss_rd,
  output logic [RW-1:0]        iss_rs1,
  output logic [RW-1:0]        iss_rs2,
  input  logic                 wb_valid,
  input  logic [RW-1:0]        wb_rd
);

  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]         ent_busy;
  logic [DEPTH-1:0]         ent_cls;
  logic [DEPTH-1:0][RW-1:0] ent_rd;
  logic [DEPTH-1:0][RW-1:0] ent_rs1;
  logic [DEPTH-1:0][RW-1:0] ent_rs2;
  logic [DEPTH-1:0][IW-1:0] ent_age;

  logic [NREG-1:0]      sb_valid;
  logic [NUM_UNITS-1:0] unit_rdy;
  logic [DEPTH-1:0]     elig;
  logic                 free_found;
  logic [IW-1:0]        free_idx;
  logic [IW-1:0]        pick_idx;
  logic [IW-1:0]        pick_age;
  logic [IW:0]          occ;
  logic [IW:0]          occ_after;
  logic [IW-1:0]        new_age;
  logic                 disp_fire;
  logic                 full;

  assign unit_rdy = {mem_ready, alu_ready};

  // eligibility: held, both sources valid, own unit ready
  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign elig[g] = ent_busy[g]
                  && sb_valid[ent_rs1[g]]
                  && sb_valid[ent_rs2[g]]
                  && unit_rdy[ent_cls[g]];
  end

  shelf_alloc #(.DEPTH(DEPTH)) u_alloc (
    .busy  (ent_busy),
    .found (free_found),
    .idx   (free_idx)
  );

  shelf_age_pick #(.DEPTH(DEPTH)) u_pick (
    .req     (elig),
    .age     (ent_age),
    .gnt_any (iss_valid),
    .gnt_idx (pick_idx)
  );

  shelf_scoreboard #(.NREG(NREG)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (wb_valid),
    .set_idx (wb_rd),
    .clr_en  (iss_valid),
    .clr_idx (iss_rd),
    .valid_o (sb_valid)
  );

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) begin
      occ = occ + (IW + 1)'(ent_busy[i]);
    end
  end

  assign full       = !free_found;
  assign disp_ready = free_found && ren_free && rob_free;
  assign disp_fire  = disp_valid && disp_ready;

  // a new entry ranks behind everything that stays after this edge
  assign occ_after = occ - (IW + 1)'(iss_valid);
  assign new_age   = occ_after[IW-1:0];

  assign pick_age = ent_age[pick_idx];
  assign iss_rd   = ent_rd[pick_idx];
  assign iss_rs1  = ent_rs1[pick_idx];
  assign iss_rs2  = ent_rs2[pick_idx];
  assign iss_unit = iss_valid ? unit_onehot(ent_cls[pick_idx]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_busy <= '0;
      ent_age  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (iss_valid && ent_busy[i] && (ent_age[i] > pick_age)) begin
          ent_age[i] <= ent_age[i] - IW'(1);
        end
      end
      if (iss_valid) ent_busy[pick_idx] <= 1'b0;
      if (disp_fire) begin
        ent_busy[free_idx] <= 1'b1;
        ent_age[free_idx]  <= new_age;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (disp_fire) begin
      ent_cls[free_idx] <= disp_cls;
      ent_rd[free_idx]  <= disp_rd;
      ent_rs1[free_idx] <= disp_rs1;
      ent_rs2[free_idx] <= disp_rs2;
    end
  end

endmodule

// File: rtl/shelf_issue_chk.sv
module shelf_issue_chk #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_ready,
  input logic            ren_free,
  input logic            rob_free,
  input logic            alu_ready,
  input logic            mem_ready,
  input logic            iss_valid,
  input logic [1:0]      iss_unit,
  input logic [RW-1:0]   iss_rd,
  input logic [RW-1:0]   iss_rs1,
  input logic [RW-1:0]   iss_rs2,
  input logic            wb_valid,
  input logic [RW-1:0]   wb_rd,
  input logic [NREG-1:0] sb_valid,
  input logic            full,
  input logic [7:0]      busy_any
);

  AST_DISP_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready |-> (ren_free && rob_free)); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready); // R9

  AST_SRC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (sb_valid[iss_rs1] && sb_valid[iss_rs2])); // R3

  AST_UNIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iss_unit) && (iss_valid == (iss_unit != 2'b00))); // R4

  AST_UNIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_unit[0] |-> alu_ready) and (iss_unit[1] |-> mem_ready)); // R4

  AST_DST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !sb_valid[$past(iss_rd)]); // R5 R7

  AST_WB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(iss_valid && (iss_rd == wb_rd))) |=> sb_valid[$past(wb_rd)]); // R6

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any == 8'd0) |-> !iss_valid); // R10

endmodule

bind shelf_issue shelf_issue_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_ready (disp_ready),
  .ren_free   (ren_free),
  .rob_free   (rob_free),
  .alu_ready  (alu_ready),
  .mem_ready  (mem_ready),
  .iss_valid  (iss_valid),
  .iss_unit   (iss_unit),
  .iss_rd     (iss_rd),
  .iss_rs1    (iss_rs1),
  .iss_rs2    (iss_rs2),
  .wb_valid   (wb_valid),
  .wb_rd      (wb_rd),
  .sb_valid   (sb_valid),
  .full       (full),
  .busy_any   (8'(occ))
);

// File: tb/tb_shelf_issue.sv
module tb_shelf_issue;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NREG = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n;
  logic          disp_valid, disp_ready, disp_cls;
  logic [RW-1:0] disp_rd, disp_rs1, disp_rs2;
  logic          ren_free, rob_free, alu_ready, mem_ready;
  logic          iss_valid;
  logic [1:0]    iss_unit;
  logic [RW-1:0] iss_rd, iss_rs1, iss_rs2;
  logic          wb_valid;
  logic [RW-1:0] wb_rd;

  shelf_issue dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_cls(disp_cls),
    .disp_rd(disp_rd), .disp_rs1(disp_rs1), .disp_rs2(disp_rs2),
    .ren_free(ren_free), .rob_free(rob_free),
    .alu_ready(alu_ready), .mem_ready(mem_ready),
    .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
    .wb_valid(wb_valid), .wb_rd(wb_rd)
  );

  int checks = 0;
  int errors = 0;

  // in-order model: index 0 is the earliest dispatched entry
  int m_n = 0;
  bit m_cls[DEPTH];
  int m_rd[DEPTH], m_rs1[DEPTH], m_rs2[DEPTH];
  bit sbm[NREG];

  task automatic chk(string req, string what, string phase, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s [%s] act=%0d exp=%0d", req, what, phase, act, exp);
    end
  endtask

  task automatic step(bit dv, bit cls, int rd, int rs1, int rs2, bit ren, bit rob,
                      bit alu, bit mem, bit wbv, int wbr, string phase);
    int k;
    bit exp_dr;
    int ird;
    @(negedge clk);
    disp_valid = dv; disp_cls = cls;
    disp_rd = RW'(rd); disp_rs1 = RW'(rs1); disp_rs2 = RW'(rs2);
    ren_free = ren; rob_free = rob; alu_ready = alu; mem_ready = mem;
    wb_valid = wbv; wb_rd = RW'(wbr);
    #1;
    exp_dr = (m_n < DEPTH) && ren && rob;
    k = -1;
    for (int i = 0; i < m_n; i++) begin
      if (k < 0 && sbm[m_rs1[i]] && sbm[m_rs2[i]] && (m_cls[i] ? mem : alu)) k = i;
    end
    chk("R2", "disp_ready", phase, int'(disp_ready), int'(exp_dr));
    chk("R3", "iss_valid", phase, int'(iss_valid), (k >= 0) ? 1 : 0);
    if (k >= 0) begin
      chk("R4", "iss_unit", phase, int'(iss_unit), m_cls[k] ? 2 : 1);
      chk("R8", "iss_rd", phase, int'(iss_rd), m_rd[k]);
      chk("R8", "iss_rs1", phase, int'(iss_rs1), m_rs1[k]);
      chk("R8", "iss_rs2", phase, int'(iss_rs2), m_rs2[k]);
    end else begin
      chk("R4", "iss_unit idle", phase, int'(iss_unit), 0);
    end
    // model update for the coming edge: writeback first, issue clear wins
    if (wbv) sbm[wbr] = 1'b1;
    if (k >= 0) begin
      ird = m_rd[k];
      sbm[ird] = 1'b0;
      for (int i = k; i < m_n - 1; i++) begin
        m_cls[i] = m_cls[i+1]; m_rd[i] = m_rd[i+1];
        m_rs1[i] = m_rs1[i+1]; m_rs2[i] = m_rs2[i+1];
      end
      m_n--;
    end
    if (dv && exp_dr) begin
      m_cls[m_n] = cls; m_rd[m_n] = rd; m_rs1[m_n] = rs1; m_rs2[m_n] = rs2;
      m_n++;
    end
  endtask

  task automatic idle(bit alu, bit mem, string phase);
    step(0, 0, 0, 0, 0, 1, 1, alu, mem, 0, 0, phase);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) sbm[r] = 1'b1;
    rst_n = 1'b0;
    disp_valid = 0; disp_cls = 0; disp_rd = '0; disp_rs1 = '0; disp_rs2 = '0;
    ren_free = 1; rob_free = 1; alu_ready = 1; mem_ready = 1;
    wb_valid = 0; wb_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "disp_ready", "reset", int'(disp_ready), 1);
    chk("R1", "iss_valid", "reset", int'(iss_valid), 0);
    chk("R1", "iss_unit", "reset", int'(iss_unit), 0);
    idle(1, 1, "R1");

    // R2 offers dropped while an allocator reports no room
    step(1, 0, 3, 0, 0, 0, 1, 1, 1, 0, 0, "R2");
    step(1, 0, 3, 0, 0, 1, 0, 1, 1, 0, 0, "R2");
    idle(1, 1, "R2");

    // R7 issue of rd 5 meets a writeback of 5; consumer of 5 must wait (R5)
    step(1, 0, 5, 0, 0, 1, 1, 0, 1, 0, 0, "R7");
    step(1, 0, 6, 5, 0, 1, 1, 1, 1, 1, 5, "R7");
    idle(1, 1, "R5");
    idle(1, 1, "R5");
    // R6 writeback visible only from the next cycle
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 5, "R6");
    idle(1, 1, "R6");

    // R4 memory entry waits on its own unit
    step(1, 1, 7, 0, 0, 1, 1, 1, 0, 0, 0, "R4");
    idle(1, 0, "R4");
    idle(0, 1, "R4");
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 6, "R6");
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 7, "R6");

    // R8/R9: make reg 9 pending, fill with mixed waiting entries
    step(1, 0, 9, 0, 0, 1, 1, 0, 0, 0, 0, "R8");
    idle(1, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, 0, 10 + i, 9, 0, 1, 1, 1, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, 1, 14 + i, 0, 9 - i, 1, 1, 1, 0, 0, 0, "R8");
    step(1, 0, 20, 0, 0, 1, 1, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, 1, 9, "R9");
    for (int i = 0; i < 6; i++) idle(1, 0, "R8");
    for (int i = 0; i < 4; i++) idle(1, 1, "R8");

    // randomised sweep over a small register set
    for (int c = 0; c < 4000; c++) begin
      step($urandom_range(0, 99) < 60, 1'($urandom_range(0, 1)),
           $urandom_range(1, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
           $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7,
           $urandom_range(0, 9) < 3, $urandom_range(0, 7), "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule